// File: doc/BRIEF.md
# Narrowband Stream Packetizer

This block takes an unbroken stream of decimated complex samples for one antenna and one polarization. Each sample has an 8-bit in-phase part and an 8-bit quadrature part. The block groups the samples into packets of a fixed length of 500 samples. It puts a short header in front of each packet and sends the result out as a byte stream. The header holds the antenna number, the polarization and a time tag. The time tag is the running count of input samples multiplied by the decimation factor, and it is taken at the first sample of the packet.

The sample input has no ready signal, because the source never waits. The output is valid/ready. A byte is transferred on every rising edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the offered byte and its markers do not change. A buffer of 1024 samples absorbs output stalls. A packet is offered only after all of its samples are in that buffer. If a sample arrives while the buffer is full, the whole packet being assembled is thrown away, together with the remaining samples of its 500-sample window, and an overflow counter advances. The configuration inputs and the counter are plain signals with no handshake.

Top module: `nbp_packetizer`

## Requirements
- R1: During reset and immediately after it, `out_valid`, `out_first` and `out_last` are low and `ovf_count` is zero.
- R2: Every packet is exactly 1006 bytes long: 6 header bytes followed by 1000 payload bytes. `out_first` is high only on the first header byte and `out_last` only on the final payload byte.
- R3: The header byte order is fixed:
  - byte 0 is the antenna number;
  - byte 1 carries the polarization in bit 0, with bits 7..1 at zero;
  - bytes 2 to 5 are the 32-bit time tag, most significant byte first.
- R4: The payload holds the samples in the order they arrived. For each sample the I byte is sent first and the Q byte second.
- R5: The time tag is the sum of `cfg_decim` over all input samples that arrived since reset and before the packet's first sample, counted modulo 2^32. With a constant decimation factor, consecutive packets therefore differ by 500 times that factor, and dropped windows still advance it.
- R6: The antenna number and polarization in a header are the values of `cfg_antenna` and `cfg_pol` in the cycle when the packet's first sample was accepted.
- R7: A packet is never offered until all 500 of its samples are buffered. No byte is offered unless a complete packet is waiting.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_first` and `out_last` keep their values and `out_valid` stays high.
- R9: A sample that arrives while the buffer holds 1024 samples has the following effect:
  - the packet being assembled is discarded;
  - the following samples up to the next 500-sample boundary are also discarded;
  - `ovf_count` increases by exactly one;
  - packets that were already complete are still sent intact.
- R10: If a second complete packet is already buffered when the last byte of a packet is transferred, the first header byte of the second packet is offered in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_antenna | input | 8 | Antenna number placed in headers |
| cfg_pol | input | 1 | Polarization bit placed in headers |
| cfg_decim | input | 16 | Time-tag increment per input sample |
| in_valid | input | 1 | A sample is present this cycle |
| in_i | input | 8 | In-phase part of the sample |
| in_q | input | 8 | Quadrature part of the sample |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte is offered |
| out_ready | input | 1 | Consumer accepts the offered byte |
| out_first | output | 1 | Offered byte is the first of a packet |
| out_last | output | 1 | Offered byte is the last of a packet |
| ovf_count | output | 16 | Number of discarded packets (wraps) |

## Verification
Two functions can fall in the same clock edge. One is the final payload byte of one packet leaving the block, which frees the descriptor and buffer space. The other is the commit of a newly completed packet, or an overflow decision made against the buffer occupancy. The bench provokes both by stalling the output with `out_ready` low while samples keep arriving every cycle, and then releasing it. This fills the buffer to its limit and queues two packets at once. Judgement uses an independent model of buffer occupancy, driven by the bytes the bench itself accepted. From that model the bench predicts which windows are dropped, the exact `ovf_count` in each cycle, and whether a header must follow the last byte without a gap.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_HDR  = 2'd1,
    EM_PAY  = 2'd2
  } em_state_t;

  localparam int NBP_FIXED_HDR_BYTES = 2;

  function automatic int hdr_bytes(input int tag_w);
    return NBP_FIXED_HDR_BYTES + tag_w / 8;
  endfunction

endpackage

// File: rtl/nbp_sample_ram.sv
module nbp_sample_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nbp_desc_fifo.sv
module nbp_desc_fifo #(
  parameter int W   = 41,
  parameter int AW  = 2,
  localparam int NE = 1 << AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [AW:0]  count
);

  logic [W-1:0] slots [NE];
  logic [AW:0]  wp, rp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) begin
        slots[wp[AW-1:0]] <= push_data;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
    end
  end

  assign head  = slots[rp[AW-1:0]];
  assign count = wp - rp;

endmodule

// File: rtl/nbp_ingest.sv
module nbp_ingest #(
  parameter int ANT_W   = 8,
  parameter int TAG_W   = 32,
  parameter int DEC_W   = 16,
  parameter int SAMPLES = 500,
  parameter int DEPTH   = 1024,
  parameter int OVF_W   = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(SAMPLES),
  localparam int DESC_W = ANT_W + 1 + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_i,
  input  logic [7:0]        in_q,
  input  logic [ANT_W-1:0]  cfg_antenna,
  input  logic              cfg_pol,
  input  logic [DEC_W-1:0]  cfg_decim,
  input  logic [AW:0]       rd_ptr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [15:0]       wr_data,
  output logic              desc_push,
  output logic [DESC_W-1:0] desc_data,
  output logic [OVF_W-1:0]  ovf_count,
  output logic [AW:0]       occ
);

  localparam logic [CW-1:0] LAST_IDX = CW'(SAMPLES - 1);
  localparam logic [AW:0]   FULL_OCC = (AW + 1)'(DEPTH);

  logic [CW-1:0]    win_idx;
  logic             discarding;
  logic [AW:0]      wr_ptr, base_ptr;
  logic [TAG_W-1:0] tag_ctr, pend_tag;
  logic [ANT_W-1:0] pend_ant;
  logic             pend_pol;
  logic             full, at_last, at_first, take, hit;

  always_comb begin
    occ      = wr_ptr - rd_ptr;
    full     = (occ == FULL_OCC);
    at_last  = (win_idx == LAST_IDX);
    at_first = (win_idx == '0);
    take     = in_valid && !discarding && !full;
    hit      = in_valid && !discarding && full;
    wr_en    = take;
    wr_addr  = wr_ptr[AW-1:0];
    wr_data  = {in_i, in_q};
    desc_push = take && at_last;
    if (at_first) desc_data = {cfg_antenna, cfg_pol, tag_ctr};
    else          desc_data = {pend_ant, pend_pol, pend_tag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_idx    <= '0;
      discarding <= 1'b0;
      wr_ptr     <= '0;
      base_ptr   <= '0;
      tag_ctr    <= '0;
      pend_tag   <= '0;
      pend_ant   <= '0;
      pend_pol   <= 1'b0;
      ovf_count  <= '0;
    end else if (in_valid) begin
      tag_ctr    <= tag_ctr + TAG_W'(cfg_decim);
      win_idx    <= at_last ? '0 : win_idx + 1'b1;
      discarding <= at_last ? 1'b0 : (discarding | full);
      if (take) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (at_first) begin
          pend_tag <= tag_ctr;
          pend_ant <= cfg_antenna;
          pend_pol <= cfg_pol;
        end
        if (at_last) base_ptr <= wr_ptr + 1'b1;
      end
      if (hit) begin
        wr_ptr    <= base_ptr;
        ovf_count <= ovf_count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nbp_emitter.sv
module nbp_emitter
  import nbp_pkg::*;
#(
  parameter int ANT_W   = 8,
  parameter int TAG_W   = 32,
  parameter int SAMPLES = 500,
  parameter int DEPTH   = 1024,
  parameter int DESC_AW = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(SAMPLES),
  localparam int HDR_N  = hdr_bytes(TAG_W),
  localparam int HW     = $clog2(HDR_N),
  localparam int DESC_W = ANT_W + 1 + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DESC_W-1:0] desc_head,
  input  logic [DESC_AW:0]  desc_count,
  output logic              desc_pop,
  output logic [AW:0]       rd_ptr,
  input  logic [15:0]       rd_data,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_first,
  output logic              out_last
);

  localparam logic [HW-1:0] HDR_LAST = HW'(HDR_N - 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(SAMPLES - 1);

  em_state_t        state;
  logic [HW-1:0]    hdr_idx;
  logic [CW-1:0]    smp_idx;
  logic             q_half;
  logic             fire;
  logic [ANT_W-1:0] h_ant;
  logic             h_pol;
  logic [TAG_W-1:0] h_tag;
  logic [TAG_W-1:0] tag_shift;

  assign {h_ant, h_pol, h_tag} = desc_head;

  always_comb begin
    out_valid = (state != EM_IDLE);
    out_first = (state == EM_HDR) && (hdr_idx == '0);
    out_last  = (state == EM_PAY) && q_half && (smp_idx == SMP_LAST);
    fire      = out_valid && out_ready;
    desc_pop  = fire && out_last;
    tag_shift = h_tag >> (8 * (int'(HDR_LAST) - int'(hdr_idx)));
    out_data  = 8'h00;
    if (state == EM_HDR) begin
      if (hdr_idx == '0)      out_data = 8'(h_ant);
      else if (hdr_idx == 1)  out_data = {7'b0, h_pol};
      else                    out_data = tag_shift[7:0];
    end else if (state == EM_PAY) begin
      out_data = q_half ? rd_data[7:0] : rd_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= EM_IDLE;
      hdr_idx <= '0;
      smp_idx <= '0;
      q_half  <= 1'b0;
      rd_ptr  <= '0;
    end else begin
      case (state)
        EM_IDLE: begin
          if (desc_count != '0) begin
            state   <= EM_HDR;
            hdr_idx <= '0;
          end
        end
        EM_HDR: begin
          if (fire) begin
            if (hdr_idx == HDR_LAST) begin
              state   <= EM_PAY;
              smp_idx <= '0;
              q_half  <= 1'b0;
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
            end
          end
        end
        EM_PAY: begin
          if (fire) begin
            if (!q_half) begin
              q_half <= 1'b1;
            end else begin
              q_half <= 1'b0;
              rd_ptr <= rd_ptr + 1'b1;
              if (smp_idx == SMP_LAST) begin
                hdr_idx <= '0;
                state   <= (desc_count > (DESC_AW + 1)'(1)) ? EM_HDR : EM_IDLE;
              end else begin
                smp_idx <= smp_idx + 1'b1;
              end
            end
          end
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nbp_packetizer.sv
module nbp_packetizer
  import nbp_pkg::*;
#(
  parameter int ANT_W   = 8,
  parameter int TAG_W   = 32,
  parameter int DEC_W   = 16,
  parameter int SAMPLES = 500,
  parameter int DEPTH   = 1024,
  parameter int OVF_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANT_W-1:0] cfg_antenna,
  input  logic             cfg_pol,
  input  logic [DEC_W-1:0] cfg_decim,
  input  logic             in_valid,
  input  logic [7:0]       in_i,
  input  logic [7:0]       in_q,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_first,
  output logic             out_last,
  output logic [OVF_W-1:0] ovf_count
);

  localparam int AW        = $clog2(DEPTH);
  localparam int DESC_W    = ANT_W + 1 + TAG_W;
  localparam int DESC_AW   = $clog2(DEPTH / SAMPLES + 1);
  localparam int PKT_BYTES = hdr_bytes(TAG_W) + 2 * SAMPLES;

  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [15:0]       wr_data, rd_data;
  logic [AW:0]       rd_ptr, fifo_occ;
  logic              desc_push, desc_pop;
  logic [DESC_W-1:0] desc_in, desc_head;
  logic [DESC_AW:0]  desc_count;

  nbp_ingest #(
    .ANT_W(ANT_W), .TAG_W(TAG_W), .DEC_W(DEC_W),
    .SAMPLES(SAMPLES), .DEPTH(DEPTH), .OVF_W(OVF_W)
  ) u_ingest (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_antenna(cfg_antenna), .cfg_pol(cfg_pol), .cfg_decim(cfg_decim),
    .rd_ptr(rd_ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .desc_push(desc_push), .desc_data(desc_in),
    .ovf_count(ovf_count), .occ(fifo_occ)
  );

  nbp_sample_ram #(.W(16), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_ptr[AW-1:0]), .rd_data(rd_data)
  );

  nbp_desc_fifo #(.W(DESC_W), .AW(DESC_AW)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .push(desc_push), .push_data(desc_in),
    .pop(desc_pop), .head(desc_head), .count(desc_count)
  );

  nbp_emitter #(
    .ANT_W(ANT_W), .TAG_W(TAG_W), .SAMPLES(SAMPLES),
    .DEPTH(DEPTH), .DESC_AW(DESC_AW)
  ) u_emit (
    .clk(clk), .rst_n(rst_n),
    .desc_head(desc_head), .desc_count(desc_count), .desc_pop(desc_pop),
    .rd_ptr(rd_ptr), .rd_data(rd_data),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_first(out_first), .out_last(out_last)
  );

endmodule

// File: rtl/nbp_packetizer_chk.sv
module nbp_packetizer_chk #(
  parameter int PKT_BYTES = 1006,
  parameter int DEPTH     = 1024,
  parameter int OCC_W     = 11,
  parameter int OVF_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_first,
  input logic             out_last,
  input logic [OVF_W-1:0] ovf_count,
  input logic [OCC_W-1:0] occ
);

  localparam int BW = $clog2(PKT_BYTES + 1);

  logic [BW-1:0] byte_ctr;
  logic          fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                byte_ctr <= '0;
    else if (fire && out_last) byte_ctr <= '0;
    else if (fire)             byte_ctr <= byte_ctr + 1'b1;
  end

  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_first) && $stable(out_last)));

  a_r2_marker_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_first && out_last));

  a_r2_last_at_len: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |-> (byte_ctr == BW'(PKT_BYTES - 1)));

  a_r2_first_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> (byte_ctr == '0));

  a_r9_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_count == $past(ovf_count)) ||
              (ovf_count == $past(ovf_count) + 1'b1)));

  a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

endmodule

bind nbp_packetizer nbp_packetizer_chk #(
  .PKT_BYTES(PKT_BYTES), .DEPTH(DEPTH), .OCC_W(AW + 1), .OVF_W(OVF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_first(out_first), .out_last(out_last),
  .ovf_count(ovf_count), .occ(fifo_occ)
);

// File: tb/nbp_packetizer_tb_top.sv
module nbp_packetizer_tb_top;

  localparam int SPP   = 500;
  localparam int DEPTH = 1024;
  localparam int HDR   = 6;
  localparam int PKT   = HDR + 2 * SPP;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_antenna;
  logic        cfg_pol;
  logic [15:0] cfg_decim;
  logic        in_valid;
  logic [7:0]  in_i, in_q;
  logic [7:0]  out_data;
  logic        out_valid, out_ready, out_first, out_last;
  logic [15:0] ovf_count;

  always #2 clk = ~clk;

  nbp_packetizer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_antenna(cfg_antenna), .cfg_pol(cfg_pol),
    .cfg_decim(cfg_decim), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_first(out_first), .out_last(out_last), .ovf_count(ovf_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // independent model state
  int          wr_m, base_m, rd_m, cnt_m;
  bit          drop_m;
  logic [31:0] tag_m;
  logic [15:0] ovf_m;
  logic [15:0] cur_smp [SPP];
  logic [7:0]  cur_ant;
  logic        cur_pol;
  logic [31:0] cur_tag;
  logic [7:0]  exp_q [$];
  int          committed, emitted, pos;
  bit          exp_b2b, prev_stall, saw_b2b;
  logic [7:0]  prev_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] hdr_byte(input int k, input logic [7:0] a,
                                          input logic p, input logic [31:0] t);
    if (k == 0) return a;
    if (k == 1) return {7'b0, p};
    return t[8*(5-k) +: 8];
  endfunction

  function automatic string req_of(input int k);
    if (k < 2)   return "R3 R6 header";
    if (k < HDR) return "R5 time tag";
    return "R4 payload";
  endfunction

  // ingest model for the coming edge
  task automatic model_in(input logic [7:0] i, input logic [7:0] q);
    bit last;
    last = (cnt_m == SPP - 1);
    if (drop_m) begin
      if (last) drop_m = 0;
    end else if (wr_m - rd_m == DEPTH) begin
      ovf_m++;
      wr_m = base_m;
      drop_m = !last;
    end else begin
      if (cnt_m == 0) begin
        cur_ant = cfg_antenna; cur_pol = cfg_pol; cur_tag = tag_m;
      end
      cur_smp[cnt_m] = {i, q};
      wr_m++;
      if (last) begin
        for (int k = 0; k < HDR; k++) exp_q.push_back(hdr_byte(k, cur_ant, cur_pol, cur_tag));
        for (int k = 0; k < SPP; k++) begin
          exp_q.push_back(cur_smp[k][15:8]);
          exp_q.push_back(cur_smp[k][7:0]);
        end
        base_m = wr_m;
        committed++;
      end
    end
    tag_m += {16'b0, cfg_decim};
    cnt_m = last ? 0 : cnt_m + 1;
  endtask

  task automatic step(input bit v, input bit r);
    bit rd_inc;
    logic [7:0] i, q;
    @(negedge clk);
    i = 8'($urandom); q = 8'($urandom);
    in_valid = v; in_i = i; in_q = q; out_ready = r;
    rd_inc = 0;
    chk(ovf_count == ovf_m, "R9 ovf_count", ovf_count, ovf_m);
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R8 hold", out_data, prev_data);
    if (exp_b2b) begin
      chk(out_valid && out_first, "R10 back to back", out_valid, 1);
      exp_b2b = 0;
      saw_b2b = 1;
    end
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 early offer", out_data, 0);
      end else begin
        chk(out_data == exp_q[0], req_of(pos), out_data, exp_q[0]);
        chk(out_first == (pos == 0) && out_last == (pos == PKT - 1),
            "R2 markers", {out_first, out_last}, {pos == 0, pos == PKT - 1});
        if (r) begin
          void'(exp_q.pop_front());
          if (pos >= HDR && ((pos - HDR) % 2 == 1)) rd_inc = 1;
          if (pos == PKT - 1) begin
            if (committed - emitted >= 2) exp_b2b = 1;
            emitted++;
            pos = 0;
          end else pos++;
        end
      end
    end
    prev_stall = out_valid && !r;
    prev_data  = out_data;
    if (v) model_in(i, q);
    if (rd_inc) rd_m++;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; in_valid = 0; in_i = 0; in_q = 0; out_ready = 0;
    cfg_antenna = 8'h2A; cfg_pol = 0; cfg_decim = 16'd7;
    wr_m = 0; base_m = 0; rd_m = 0; cnt_m = 0; drop_m = 0; tag_m = 0; ovf_m = 0;
    committed = 0; emitted = 0; pos = 0; exp_b2b = 0; prev_stall = 0; saw_b2b = 0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_first && !out_last, "R1 reset outputs", out_valid, 0);
    chk(ovf_count == 0, "R1 reset ovf_count", ovf_count, 0);
    @(negedge clk); rst_n = 1;
    chk(!out_valid && ovf_count == 0, "R1 after reset", out_valid, 0);

    // random traffic, configuration changes mid-window (R6)
    for (int c = 0; c < 4500; c++) begin
      if (c % 700 == 350) begin cfg_antenna = 8'($urandom); cfg_pol = ~cfg_pol; end
      step(($urandom % 4) == 0, ($urandom % 4) != 0);
    end
    // stall output while input runs: overflow (R9)
    for (int c = 0; c < 1400; c++) step(1, 0);
    for (int c = 0; c < 2200; c++) step(0, 1);
    // new decimation factor (R5)
    cfg_decim = 16'd3;
    for (int c = 0; c < 4500; c++) step(($urandom % 3) == 0, ($urandom % 8) != 0);
    for (int c = 0; c < 2200; c++) step(0, 1);
    // queue two packets then release (R10)
    cfg_decim = 16'hFFFF;
    for (int c = 0; c < 1000; c++) step(1, 0);
    for (int c = 0; c < 2200; c++) step(0, ($urandom % 16) != 0);
    for (int c = 0; c < 3000 && (exp_q.size() != 0 || out_valid); c++) step(0, 1);
    step(0, 1);
    chk(exp_q.size() == 0, "R7 all packets sent", exp_q.size(), 0);
    chk(ovf_m != 0, "R9 overflow exercised", ovf_m, 1);
    chk(saw_b2b, "R10 back to back exercised", saw_b2b, 1);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule